// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received frame is kept, judging only by its 48-bit destination address. A frame parser hands over the address once per frame. The filter classifies the address as unicast, multicast or broadcast. It then applies one of two methods. The first is an exact compare against a single programmed station address. The second is an imperfect lookup, where a 6-bit index taken from a CRC-32 of the address selects one bit of a 64-bit hash table. Two mode bits choose the method for each address class. A broadcast-reject bit drops frames sent to the all-ones address, and a wake-up path can override that reject.

The address arrives on a valid/ready input. The block takes one address at a time. While it works, `da_ready` is low. A `da_valid` seen while `da_ready` is low is dropped: it is not held, queued or stalled on, so the upstream side must wait for ready if it wants the address used. The CRC is computed one bit per cycle. The verdict is registered and comes out with a single-cycle `verdict_done` pulse a fixed 49 cycles after acceptance. The result side has no back-pressure. The mode bits, station address and hash table must stay stable while an address is in flight. The per-frame wake indication is captured together with the address.

Top module: `rx_da_filter`

## Requirements
- R1: After reset `da_ready` is 1 and `verdict_done` and `verdict_accept` are 0. An address is taken on a cycle with `da_valid` and `da_ready` both high. `da_ready` is 0 from the next cycle until the verdict cycle. A `da_valid` while `da_ready` is 0 has no effect on the verdict, its timing or the number of verdicts.
- R2: `verdict_done` is high for exactly one cycle, 49 clock edges after the accepting edge. `verdict_accept` is valid in that cycle. `da_ready` is already 1 in that cycle, so a new address can be taken back to back.
- R3: Bit i of `da` is the i-th transmitted bit, so bit 0 of the first octet is `da[0]`. An address is multicast when `da[0]` is 1 and it is not all ones. With `cfg_hash_mode` and `cfg_hash_only` both 0, a non-broadcast address is accepted only if it equals `station_addr`, whatever the hash table holds.
- R4: The hash index is bits [31:26] of a CRC-32 register. The register starts at all ones and is shifted left once per address bit, `da[0]` first, with polynomial 0x04C11DB7. The XOR is applied when the bit shifted out of [31] differs from the data bit. The index selects bit `hash_table[index]`. With `cfg_hash_mode`=1 and `cfg_hash_only`=0, a multicast address is accepted exactly when that table bit is 1.
- R5: With `cfg_hash_mode`=1 and `cfg_hash_only`=0, a unicast address is still accepted only if it equals `station_addr`.
- R6: With `cfg_hash_only`=1, unicast and multicast addresses are both accepted exactly when their hash table bit is 1, whatever `cfg_hash_mode` is and whether or not the address equals `station_addr`.
- R7: The all-ones address is never hashed. With `cfg_bcast_dis`=0 it is accepted in every mode. With `cfg_bcast_dis`=1 it is rejected unless R8 applies.
- R8: When `cfg_wake_en`=1 and `wake_frame` was 1 at acceptance, a broadcast address is accepted even with `cfg_bcast_dis`=1. The wake path has no effect on non-broadcast addresses, or when `cfg_wake_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| da_valid | input | 1 | Destination address offered |
| da_ready | output | 1 | Filter idle, address will be taken |
| da | input | 48 | Destination address, bit i = i-th transmitted bit |
| wake_frame | input | 1 | Frame is a wake-up frame, captured with the address |
| cfg_hash_mode | input | 1 | Multicast filtered by hash table |
| cfg_hash_only | input | 1 | Unicast and multicast both filtered by hash table |
| cfg_bcast_dis | input | 1 | Reject broadcast frames |
| cfg_wake_en | input | 1 | Wake-up detection enabled |
| station_addr | input | 48 | Programmed station address |
| hash_table | input | 64 | Multicast hash table, one bit per index |
| verdict_done | output | 1 | One-cycle pulse, verdict valid |
| verdict_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The bound checker watches every cycle for handshake discipline, the single-cycle done pulse, the fixed 49-edge latency, and that ready is back at the verdict. It also checks the exact-match verdicts of the perfect and mixed modes, and the broadcast reject with its wake override, against a copy of the address it captures itself. Only the bench scenarios can show that the hash index is the right CRC slice, since they compare hash-mode verdicts with an independent reference model over all sixteen mode combinations. The same is true for addresses offered while busy: the bench shows they leave no trace, and that the next address is taken in the done cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_DECIDE = 2'd2
  } rxf_state_e;

  // One step of the left-shifting CRC register for one data bit.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur, input logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_wake,
  output logic              crc_init,
  output logic              crc_shift,
  output logic              crc_bit,
  output logic              decide,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wake_q
);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W - 1);

  rxf_state_e state;
  logic [CNT_W-1:0] bit_cnt;
  logic take;

  assign in_ready  = (state == ST_IDLE);
  assign take      = in_valid && in_ready;
  assign crc_init  = take;
  assign crc_shift = (state == ST_SHIFT);
  assign crc_bit   = addr_q[bit_cnt];
  assign decide    = (state == ST_DECIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      addr_q  <= '0;
      wake_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            addr_q  <= in_addr;
            wake_q  <= in_wake;
            bit_cnt <= '0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (bit_cnt == LAST_BIT) begin
            state <= ST_DECIDE;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_DECIDE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 shift,
  input  logic                 din,
  output logic [HASH_BITS-1:0] index
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (init) begin
      crc_q <= CRC_SEED;
    end else if (shift) begin
      crc_q <= crc_step(crc_q, din);
    end
  end

  assign index = crc_q[CRC_W-1 -: HASH_BITS];
endmodule

// File: rtl/rxf_addr_class.sv
module rxf_addr_class #(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] station,
  output logic              is_bcast,
  output logic              is_mcast,
  output logic              station_hit
);
  localparam int OCTETS = ADDR_W / 8;
  logic [OCTETS-1:0] octet_eq;

  for (genvar g = 0; g < OCTETS; g++) begin : g_octet
    assign octet_eq[g] = (addr[g*8 +: 8] == station[g*8 +: 8]);
  end

  assign station_hit = &octet_eq;
  assign is_bcast    = &addr;
  assign is_mcast    = addr[0] && !is_bcast;
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6,
  localparam int TABLE_W  = 1 << HASH_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               da_valid,
  output logic               da_ready,
  input  logic [ADDR_W-1:0]  da,
  input  logic               wake_frame,
  input  logic               cfg_hash_mode,
  input  logic               cfg_hash_only,
  input  logic               cfg_bcast_dis,
  input  logic               cfg_wake_en,
  input  logic [ADDR_W-1:0]  station_addr,
  input  logic [TABLE_W-1:0] hash_table,
  output logic               verdict_done,
  output logic               verdict_accept
);
  logic crc_init, crc_shift, crc_bit, decide, wake_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HASH_BITS-1:0] hash_idx;
  logic is_bcast, is_mcast, station_hit, hash_hit, verdict;

  rxf_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(da_valid), .in_ready(da_ready), .in_addr(da), .in_wake(wake_frame),
    .crc_init(crc_init), .crc_shift(crc_shift), .crc_bit(crc_bit),
    .decide(decide), .addr_q(addr_q), .wake_q(wake_q)
  );

  rxf_crc_hash #(.HASH_BITS(HASH_BITS)) hash_i (
    .clk(clk), .rst_n(rst_n),
    .init(crc_init), .shift(crc_shift), .din(crc_bit), .index(hash_idx)
  );

  rxf_addr_class #(.ADDR_W(ADDR_W)) class_i (
    .addr(addr_q), .station(station_addr),
    .is_bcast(is_bcast), .is_mcast(is_mcast), .station_hit(station_hit)
  );

  assign hash_hit = hash_table[hash_idx];

  always_comb begin
    if (is_bcast) begin
      verdict = !cfg_bcast_dis || (cfg_wake_en && wake_q);
    end else if (cfg_hash_only || (cfg_hash_mode && is_mcast)) begin
      verdict = hash_hit;
    end else begin
      verdict = station_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_done   <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_done <= decide;
      if (decide) verdict_accept <= verdict;
    end
  end
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk #(
  parameter int ADDR_W  = 48,
  parameter int TABLE_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               da_valid,
  input logic               da_ready,
  input logic [ADDR_W-1:0]  da,
  input logic               wake_frame,
  input logic               cfg_hash_mode,
  input logic               cfg_hash_only,
  input logic               cfg_bcast_dis,
  input logic               cfg_wake_en,
  input logic [ADDR_W-1:0]  station_addr,
  input logic [TABLE_W-1:0] hash_table,
  input logic               verdict_done,
  input logic               verdict_accept
);
  localparam int LAT = ADDR_W + 1;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] age;
  logic in_flight;
  logic [ADDR_W-1:0] cap_addr;
  logic cap_wake;
  logic cap_bcast;
  logic table_any;

  assign cap_bcast = &cap_addr;
  assign table_any = |hash_table;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age       <= '0;
      in_flight <= 1'b0;
      cap_addr  <= '0;
      cap_wake  <= 1'b0;
    end else if (da_valid && da_ready) begin
      age       <= '0;
      in_flight <= 1'b1;
      cap_addr  <= da;
      cap_wake  <= wake_frame;
    end else begin
      if (in_flight && age != '1) age <= age + 1'b1;
      if (verdict_done) in_flight <= 1'b0;
    end
  end

  assert_take_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ready) |=> !da_ready);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_done |=> !verdict_done);

  assert_ready_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_done |-> da_ready);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_done |-> (in_flight && age == CW'(LAT)));

  assert_perfect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_done && !cfg_hash_mode && !cfg_hash_only && !cap_bcast)
      |-> (verdict_accept == (cap_addr == station_addr)));

  assert_unicast_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_done && cfg_hash_mode && !cfg_hash_only && !cap_addr[0])
      |-> (verdict_accept == (cap_addr == station_addr)));

  assert_empty_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_done && cfg_hash_only && !cap_bcast && !table_any) |-> !verdict_accept);

  assert_bcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_done && cap_bcast) |->
      (verdict_accept == (!cfg_bcast_dis || (cfg_wake_en && cap_wake))));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_done && cap_bcast && cfg_wake_en && cap_wake) |-> verdict_accept);
endmodule

bind rx_da_filter rx_da_filter_chk #(.ADDR_W(ADDR_W), .TABLE_W(TABLE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_ready(da_ready), .da(da),
  .wake_frame(wake_frame), .cfg_hash_mode(cfg_hash_mode), .cfg_hash_only(cfg_hash_only),
  .cfg_bcast_dis(cfg_bcast_dis), .cfg_wake_en(cfg_wake_en), .station_addr(station_addr),
  .hash_table(hash_table), .verdict_done(verdict_done), .verdict_accept(verdict_accept)
);

// File: tb/rx_da_filter_tb_top.sv
module rx_da_filter_tb_top;
  localparam logic [47:0] STATION = 48'hC0FF_EE12_3456;
  localparam logic [47:0] BCAST   = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic da_valid = 1'b0;
  logic da_ready;
  logic [47:0] da = '0;
  logic wake_frame = 1'b0;
  logic cfg_hash_mode = 1'b0, cfg_hash_only = 1'b0, cfg_bcast_dis = 1'b0, cfg_wake_en = 1'b0;
  logic [47:0] station_addr = STATION;
  logic [63:0] hash_table = '0;
  logic verdict_done, verdict_accept;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_da_filter dut_i (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_ready(da_ready), .da(da),
    .wake_frame(wake_frame), .cfg_hash_mode(cfg_hash_mode), .cfg_hash_only(cfg_hash_only),
    .cfg_bcast_dis(cfg_bcast_dis), .cfg_wake_en(cfg_wake_en), .station_addr(station_addr),
    .hash_table(hash_table), .verdict_done(verdict_done), .verdict_accept(verdict_accept)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Reference hash: octet by octet, low bit of each octet first.
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int o = 0; o < 6; o++) begin
      for (int b = 0; b < 8; b++) begin
        if (r[31] != a[8*o + b]) r = (r << 1) ^ 32'h04C1_1DB7;
        else r = r << 1;
      end
    end
    return r[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a, input logic w);
    if (a == BCAST) return !cfg_bcast_dis || (cfg_wake_en && w);
    if (cfg_hash_only || (cfg_hash_mode && a[0])) return hash_table[ref_index(a)];
    return a == station_addr;
  endfunction

  task automatic set_cfg(input logic hm, input logic ho, input logic bd, input logic we);
    cfg_hash_mode = hm; cfg_hash_only = ho; cfg_bcast_dis = bd; cfg_wake_en = we;
  endtask

  // Offer an address at a falling edge; return at the falling edge after the accepting edge.
  task automatic launch(input logic [47:0] a, input logic w);
    da = a; wake_frame = w; da_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    da_valid = 1'b0;
  endtask

  // Wait for the verdict; returns in the done cycle.
  task automatic await_verdict(input logic exp, input string tag);
    int early = 0;
    for (int i = 1; i <= 49; i++) begin
      @(negedge clk);
      if (i < 49 && verdict_done) early++;
    end
    check(early == 0 && verdict_done, {tag, " done at 49 edges"}, 64'(verdict_done), 64'd1);
    check(verdict_accept == exp, {tag, " verdict"}, 64'(verdict_accept), 64'(exp));
  endtask

  task automatic run(input logic [47:0] a, input logic w, input string tag);
    logic exp;
    exp = ref_accept(a, w);
    launch(a, w);
    await_verdict(exp, tag);
    @(negedge clk);
    check(!verdict_done, {tag, " done one cycle R2"}, 64'(verdict_done), 64'd0);
  endtask

  task automatic t_reset;
    check(da_ready && !verdict_done && !verdict_accept, "R1 reset state",
          {61'd0, da_ready, verdict_done, verdict_accept}, 64'd4);
  endtask

  task automatic t_perfect;
    set_cfg(0, 0, 0, 0);
    hash_table = '1;
    run(STATION, 0, "R3 station match");
    run(STATION ^ 48'h0100, 0, "R3 unicast miss");
    run(STATION | 48'h1, 0, "R3 multicast ignores full table");
  endtask

  task automatic t_hash_mcast;
    logic [47:0] m = 48'h0A0B_0C0D_0E01;
    set_cfg(1, 0, 0, 0);
    hash_table = 64'd1 << ref_index(m);
    launch(m, 0); await_verdict(1'b1, "R4 multicast table hit"); @(negedge clk);
    hash_table = ~(64'd1 << ref_index(m));
    launch(m, 0); await_verdict(1'b0, "R4 multicast table miss"); @(negedge clk);
  endtask

  task automatic t_hash_ucast;
    set_cfg(1, 0, 0, 0);
    hash_table = '0;
    launch(STATION, 0); await_verdict(1'b1, "R5 unicast station, empty table"); @(negedge clk);
    hash_table = '1;
    launch(STATION ^ 48'h10, 0); await_verdict(1'b0, "R5 unicast other, full table"); @(negedge clk);
  endtask

  task automatic t_hash_only;
    logic [47:0] u = 48'h1234_5678_9ABC;
    for (int hm = 0; hm < 2; hm++) begin
      set_cfg(hm[0], 1, 0, 0);
      hash_table = ~(64'd1 << ref_index(STATION));
      launch(STATION, 0); await_verdict(1'b0, "R6 station missing in table"); @(negedge clk);
      hash_table = 64'd1 << ref_index(u);
      launch(u, 0); await_verdict(1'b1, "R6 other unicast hit"); @(negedge clk);
      hash_table = 64'd1 << ref_index(u | 48'h1);
      launch(u | 48'h1, 0); await_verdict(1'b1, "R6 multicast hit"); @(negedge clk);
    end
  endtask

  task automatic t_bcast;
    set_cfg(0, 1, 0, 0);
    hash_table = '0;
    launch(BCAST, 0); await_verdict(1'b1, "R7 broadcast not hashed"); @(negedge clk);
    set_cfg(0, 0, 1, 0);
    launch(BCAST, 0); await_verdict(1'b0, "R7 broadcast rejected"); @(negedge clk);
    launch(BCAST, 1); await_verdict(1'b0, "R8 wake flag without enable"); @(negedge clk);
    set_cfg(0, 0, 1, 1);
    launch(BCAST, 0); await_verdict(1'b0, "R8 enable without wake frame"); @(negedge clk);
    launch(BCAST, 1); await_verdict(1'b1, "R8 wake overrides reject"); @(negedge clk);
    launch(STATION ^ 48'h2, 1); await_verdict(1'b0, "R8 no effect on unicast"); @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    int extra = 0;
    set_cfg(0, 0, 0, 0);
    launch(STATION, 0);
    check(!da_ready, "R1 ready low after take", 64'(da_ready), 64'd0);
    for (int i = 1; i <= 49; i++) begin
      @(negedge clk);
      if (i == 10) begin da = 48'h0000_0000_0002; da_valid = 1'b1; end
      if (i == 11) da_valid = 1'b0;
      if (i == 48) check(!da_ready, "R1 ready low while busy", 64'(da_ready), 64'd0);
    end
    check(verdict_done && verdict_accept, "R1 strobe while busy ignored",
          {62'd0, verdict_done, verdict_accept}, 64'd3);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (verdict_done) extra++;
    end
    check(extra == 0 && da_ready, "R1 no verdict for dropped strobe", 64'(extra), 64'd0);
  endtask

  task automatic t_back_to_back;
    set_cfg(0, 0, 0, 0);
    launch(STATION, 0);
    await_verdict(1'b1, "R2 first of pair");
    check(da_ready, "R2 ready in done cycle", 64'(da_ready), 64'd1);
    launch(48'h0000_0000_0004, 0);
    await_verdict(1'b0, "R2 second taken in done cycle");
    @(negedge clk);
  endtask

  task automatic t_sweep;
    logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
    logic [47:0] a;
    hash_table = 64'h5A3C_96E1_0F87_D2B4;
    for (int c = 0; c < 16; c++) begin
      set_cfg(c[0], c[1], c[2], c[3]);
      for (int k = 0; k < 4; k++) begin
        s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
        case (k)
          0: a = STATION;
          1: a = STATION | 48'h1;
          2: a = s[47:0];
          default: a = BCAST;
        endcase
        run(a, s[50], "R4 sweep vs reference model");
      end
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_perfect();
    t_hash_mcast();
    t_hash_ucast();
    t_hash_only();
    t_bcast();
    t_busy_ignore();
    t_back_to_back();
    t_sweep();
    finish_run();
  end
endmodule